// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog. Software programs a reload count, arms the timer through a control word, and must then write a fixed 16-bit key to a restart register often enough to stop the count reaching zero. When the count does reach zero, the block emits a one-cycle timeout pulse and halts. Depending on the control word, it also raises an interrupt request and drives a reset request. The reset request lasts a programmed number of 1 MHz ticks, at a polarity that software chooses.

The counter runs either on every system clock (the fast peripheral tick, optionally divided by a parameter) or on an external 1 MHz tick enable. A control bit selects between them. Writes to the control word take effect only when they change the enable state. The reset-shape register changes its polarity and drive-type flags only through 8-bit command codes placed in its top byte. Each write to that register also replaces its low pulse-width field, whose width is a parameter.

The bus side uses a word address and single-cycle strobes. Read data is registered and becomes valid in the cycle after the read strobe.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the live count and the reload value both read 0x03EF1480, control reads 0, and the reset-shape register reads 0x000000FF. The timeout and interrupt outputs are low, and the reset request sits at its inactive level, which is high because bit 31 is clear.
- R2: Word address 0 reads the live count, 1 the reload value, 3 the control word and 6 the reset-shape register. Addresses 2, 4 and 5, and every unlisted address, read zero. Writes to addresses 0, 4 and 5 change nothing. Read data appears one clock after the read strobe.
- R3: A write to word address 2 whose bits 15:0 equal 0x4755 loads the count from the reload value. The countdown resumes if control bit 0 is set. Any other value is ignored, and bits 31:16 are not compared.
- R4: A control write with bit 0 set while the timer is disabled stores the whole word and starts counting from the reload value. A control write with bit 0 clear while the timer is enabled stores the word and freezes the count. Any control write that leaves bit 0 unchanged is discarded entirely.
- R5: While running, the count decrements by one on each selected tick. With control bit 4 set, the tick is the 1 MHz input. With bit 4 clear, the tick is every PCLK_DIV-th system clock, which is every clock by default.
- R6: A tick that finds the count at 1 or 0 sets the count to 0, raises the timeout output for exactly one clock in the same edge, and stops the timer until a valid restart or a fresh enable.
- R7: An expiry with control bit 2 set raises the interrupt request one clock after the timeout pulse. The request stays high until a valid restart or an accepted control write.
- R8: An expiry with control bit 1 set drives the reset request active one clock after the timeout pulse. It holds the active level for the number of 1 MHz ticks in the pulse-width field, with a minimum of one tick. The active level is high when bit 31 of the reset-shape register is set and low when it is clear.
- R9: In a reset-shape write, top byte 0xA5 sets bit 31 and 0x5A clears it. Top byte 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31 and 30 unchanged.
- R10: Every reset-shape write replaces only bits PULSE_W-1:0 (20 by default) from the write data. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_1mhz_i | input | 1 | One-cycle enable at 1 MHz |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| timeout_o | output | 1 | One-cycle expiry pulse |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | Reset request at the programmed polarity |

## Verification
The bench aims first at the enable-edge rule. A design that stored every control write would change the control read-back, or stop the counter, when a same-state word arrives. The bench also probes the restart key with a wrong low half and with junk in the upper half: a design that compared all 32 bits, or ignored the key, would show a wrong count. Expiry timing is measured cycle by cycle at the fast tick, and the count is checked to hold at zero afterwards. An off-by-one decrement would move the pulse, and a design that kept running would wrap the count. The reset-shape register is driven with every command code, a non-command top byte and an all-ones field. The reset pulse is counted in 1 MHz ticks at both polarities, so an inverted polarity or a width miscount shows directly on the reset request output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned DATA_W = 32;

   // word addresses of the register slots
   localparam int unsigned A_COUNT  = 0;
   localparam int unsigned A_RELOAD = 1;
   localparam int unsigned A_KICK   = 2;
   localparam int unsigned A_CTRL   = 3;
   localparam int unsigned A_TOSTAT = 4;
   localparam int unsigned A_TOCLR  = 5;
   localparam int unsigned A_SHAPE  = 6;

   // control word bit positions
   localparam int unsigned C_ENABLE = 0;
   localparam int unsigned C_RSTSYS = 1;
   localparam int unsigned C_IRQEN  = 2;
   localparam int unsigned C_EXTSIG = 3;
   localparam int unsigned C_SLOW   = 4;
   localparam int unsigned C_FULL   = 5;

   localparam logic [15:0] KICK_KEY = 16'h4755;

   // reset-shape register command codes (top byte)
   localparam logic [7:0] CMD_POL_HIGH = 8'hA5;
   localparam logic [7:0] CMD_POL_LOW  = 8'h5A;
   localparam logic [7:0] CMD_PUSHPULL = 8'hA8;
   localparam logic [7:0] CMD_OPENDRN  = 8'h8A;

   localparam logic [DATA_W-1:0] COUNT_INIT = 32'h03EF_1480;
   localparam logic [DATA_W-1:0] SHAPE_INIT = 32'h0000_00FF;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
   parameter int unsigned PCLK_DIV = 1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic slow_sel_i,
   input  logic tick_1mhz_i,
   output logic tick_o
);
   localparam int unsigned DIV_W = (PCLK_DIV > 1) ? $clog2(PCLK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PCLK_DIV - 1);

   generate
      if (PCLK_DIV < 1) begin : g_bad_div
         $error("PCLK_DIV must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             fast_tick;

   assign fast_tick = (div_q == DIV_LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i)          div_q <= '0;
      else if (fast_tick) div_q <= '0;
      else                div_q <= div_q + 1'b1;
   end

   assign tick_o = slow_sel_i ? tick_1mhz_i : fast_tick;

   // R5: the prescaler never passes its terminal value
   a_r5_div_range: assert property (@(posedge clk_i) disable iff (rst_i)
      fast_tick |=> (div_q == '0));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned PULSE_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] count_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] reload_o,
   output logic              enable_o,
   output logic              slow_o,
   output logic              irq_en_o,
   output logic              rst_en_o,
   output logic              active_high_o,
   output logic [PULSE_W-1:0] pulse_w_o,
   output logic              load_o,
   output logic              run_o,
   output logic              stop_o,
   output logic              clr_o
);
   localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((64'd1 << PULSE_W) - 64'd1);

   generate
      if (PULSE_W < 1 || PULSE_W > 24) begin : g_bad_pw
         $error("PULSE_W must lie in 1..24");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W must reach word address 6");
      end
   endgenerate

   logic [DATA_W-1:0] reload_q, ctrl_q, shape_q, shape_d;
   logic wr_reload, wr_kick, wr_ctrl, wr_shape;
   logic kick_ok, en_on, en_off;

   assign wr_reload = wr_en_i && (addr_i == ADDR_W'(A_RELOAD));
   assign wr_kick   = wr_en_i && (addr_i == ADDR_W'(A_KICK));
   assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
   assign wr_shape  = wr_en_i && (addr_i == ADDR_W'(A_SHAPE));

   assign kick_ok = wr_kick && (wdata_i[15:0] == KICK_KEY);
   assign en_on   = wr_ctrl &&  wdata_i[C_ENABLE] && !ctrl_q[C_ENABLE];
   assign en_off  = wr_ctrl && !wdata_i[C_ENABLE] &&  ctrl_q[C_ENABLE];

   assign load_o = kick_ok || en_on;
   assign run_o  = en_on || ctrl_q[C_ENABLE];
   assign stop_o = en_off;
   assign clr_o  = kick_ok || en_on || en_off;

   always_comb begin
      shape_d = shape_q;
      case (wdata_i[31:24])
         CMD_POL_HIGH: shape_d[31] = 1'b1;
         CMD_POL_LOW:  shape_d[31] = 1'b0;
         CMD_PUSHPULL: shape_d[30] = 1'b1;
         CMD_OPENDRN:  shape_d[30] = 1'b0;
         default:      ;
      endcase
      shape_d = (shape_d & ~FIELD_MASK) | (wdata_i & FIELD_MASK);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         reload_q <= COUNT_INIT;
         ctrl_q   <= '0;
         shape_q  <= SHAPE_INIT;
      end else begin
         if (wr_reload)       reload_q <= wdata_i;
         if (en_on || en_off) ctrl_q   <= wdata_i;
         if (wr_shape)        shape_q  <= shape_d;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rdata_o <= '0;
      end else if (rd_en_i) begin
         case (addr_i)
            ADDR_W'(A_COUNT):  rdata_o <= count_i;
            ADDR_W'(A_RELOAD): rdata_o <= reload_q;
            ADDR_W'(A_CTRL):   rdata_o <= ctrl_q;
            ADDR_W'(A_SHAPE):  rdata_o <= shape_q;
            default:           rdata_o <= '0;
         endcase
      end
   end

   assign reload_o      = reload_q;
   assign enable_o      = ctrl_q[C_ENABLE];
   assign slow_o        = ctrl_q[C_SLOW];
   assign irq_en_o      = ctrl_q[C_IRQEN];
   assign rst_en_o      = ctrl_q[C_RSTSYS];
   assign active_high_o = shape_q[31];
   assign pulse_w_o     = shape_q[PULSE_W-1:0];

   // R4: a control write that keeps the enable state leaves control untouched
   a_r4_same_state_discard: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_ctrl && (wdata_i[C_ENABLE] == enable_o)) |=> $stable(enable_o) && $stable(slow_o)
         && $stable(irq_en_o) && $stable(rst_en_o));

   // R9: a non-command top byte keeps the polarity and drive flags
   a_r9_flags_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_shape && wdata_i[31:24] != CMD_POL_HIGH && wdata_i[31:24] != CMD_POL_LOW
         && wdata_i[31:24] != CMD_PUSHPULL && wdata_i[31:24] != CMD_OPENDRN)
      |=> $stable(shape_q[31:30]));

   // R10: the pulse-width field follows the written data
   a_r10_field_copy: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_shape |=> (pulse_w_o == $past(wdata_i[PULSE_W-1:0])));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic              run_i,
   input  logic              stop_i,
   input  logic [DATA_W-1:0] reload_i,
   output logic [DATA_W-1:0] count_o,
   output logic              timeout_o
);
   logic [DATA_W-1:0] count_q;
   logic              running_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q   <= COUNT_INIT;
         running_q <= 1'b0;
         timeout_o <= 1'b0;
      end else begin
         timeout_o <= 1'b0;
         if (load_i) begin
            count_q   <= reload_i;
            running_q <= run_i;
         end else if (stop_i) begin
            running_q <= 1'b0;
         end else if (running_q && tick_i) begin
            if (count_q < DATA_W'(2)) begin
               count_q   <= '0;
               running_q <= 1'b0;
               timeout_o <= 1'b1;
            end else begin
               count_q <= count_q - 1'b1;
            end
         end
      end
   end

   assign count_o = count_q;

   // R6: the timeout is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
      timeout_o |=> !timeout_o);

   // R6: expiry leaves the count at zero and the timer halted
   a_r6_zero_on_expiry: assert property (@(posedge clk_i) disable iff (rst_i)
      timeout_o |-> (count_o == '0) && !running_q);

   // R3: a load takes the reload value
   a_r3_load_value: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (count_o == $past(reload_i)));

   // R5: a halted timer holds its count
   a_r5_hold_when_halted: assert property (@(posedge clk_i) disable iff (rst_i)
      (!running_q && !load_i) |=> $stable(count_o));
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm #(
   parameter int unsigned PULSE_W = 20
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               tick_1mhz_i,
   input  logic               timeout_i,
   input  logic               irq_en_i,
   input  logic               rst_en_i,
   input  logic               active_high_i,
   input  logic [PULSE_W-1:0] pulse_w_i,
   input  logic               clr_i,
   output logic               irq_o,
   output logic               rst_req_o
);
   logic [PULSE_W-1:0] left_q;
   logic               active_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)                       irq_o <= 1'b0;
      else if (timeout_i && irq_en_i)  irq_o <= 1'b1;
      else if (clr_i)                  irq_o <= 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         active_q <= 1'b0;
         left_q   <= '0;
      end else if (timeout_i && rst_en_i) begin
         active_q <= 1'b1;
         left_q   <= pulse_w_i;
      end else if (active_q && tick_1mhz_i) begin
         if (left_q < PULSE_W'(2)) begin
            active_q <= 1'b0;
            left_q   <= '0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign rst_req_o = active_high_i ? active_q : !active_q;

   // R7: the interrupt only rises after an expiry with the interrupt enabled
   a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(irq_o) |-> $past(timeout_i && irq_en_i));

   // R8: the reset pulse only starts after an expiry with reset enabled
   a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(active_q) |-> $past(timeout_i && rst_en_i));

   // R8: the pulse only ends on a 1 MHz tick
   a_r8_ends_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(active_q) |-> $past(tick_1mhz_i));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned PULSE_W  = 20,
   parameter int unsigned PCLK_DIV = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              tick_1mhz_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              timeout_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   logic [DATA_W-1:0]  count, reload;
   logic [PULSE_W-1:0] pulse_w;
   logic enable, slow, irq_en, rst_en, active_high;
   logic load, run, stop, clr, tick;

   wdt_regfile #(.ADDR_W(ADDR_W), .PULSE_W(PULSE_W)) u_regs (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .wr_en_i      (wr_en_i),
      .rd_en_i      (rd_en_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .count_i      (count),
      .rdata_o      (rdata_o),
      .reload_o     (reload),
      .enable_o     (enable),
      .slow_o       (slow),
      .irq_en_o     (irq_en),
      .rst_en_o     (rst_en),
      .active_high_o(active_high),
      .pulse_w_o    (pulse_w),
      .load_o       (load),
      .run_o        (run),
      .stop_o       (stop),
      .clr_o        (clr)
   );

   wdt_tick_sel #(.PCLK_DIV(PCLK_DIV)) u_tick (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .slow_sel_i  (slow),
      .tick_1mhz_i (tick_1mhz_i),
      .tick_o      (tick)
   );

   wdt_counter u_count (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tick_i    (tick),
      .load_i    (load),
      .run_i     (run),
      .stop_i    (stop),
      .reload_i  (reload),
      .count_o   (count),
      .timeout_o (timeout_o)
   );

   wdt_alarm #(.PULSE_W(PULSE_W)) u_alarm (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .tick_1mhz_i   (tick_1mhz_i),
      .timeout_i     (timeout_o),
      .irq_en_i      (irq_en),
      .rst_en_i      (rst_en),
      .active_high_i (active_high),
      .pulse_w_i     (pulse_w),
      .clr_i         (clr),
      .irq_o         (irq_o),
      .rst_req_o     (rst_req_o)
   );

   // R6: an expiry needs the timer to have been enabled
   a_r6_needs_enable: assert property (@(posedge clk_i) disable iff (rst_i)
      timeout_o |-> $past(enable));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        timeout, irq, rst_req;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_watchdog u_dut (
      .clk_i(clk), .rst_i(rst), .tick_1mhz_i(tick),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata),
      .timeout_o(timeout), .irq_o(irq), .rst_req_o(rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic tick1m();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 timeout", {31'd0, timeout}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 rst_req idle high", {31'd0, rst_req}, 32'd1);
      rd(4'd0, v); chk("R1 count", v, 32'h03EF1480);
      rd(4'd1, v); chk("R1 reload", v, 32'h03EF1480);
      rd(4'd3, v); chk("R1 ctrl", v, 32'h0);
      rd(4'd6, v); chk("R1 shape", v, 32'h000000FF);
   endtask

   task automatic t_map();
      logic [31:0] v;
      wr(4'd0, 32'h0000_1234);
      rd(4'd0, v); chk("R2 count write ignored", v, 32'h03EF1480);
      wr(4'd4, 32'hFFFF_FFFF);
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd4, v); chk("R2 addr4 zero", v, 32'h0);
      rd(4'd5, v); chk("R2 addr5 zero", v, 32'h0);
      rd(4'd2, v); chk("R2 addr2 zero", v, 32'h0);
      rd(4'd7, v); chk("R2 addr7 zero", v, 32'h0);
      rd(4'd15, v); chk("R2 addr15 zero", v, 32'h0);
      rd(4'd3, v); chk("R2 ctrl untouched", v, 32'h0);
      rd(4'd6, v); chk("R2 shape untouched", v, 32'h000000FF);
   endtask

   task automatic t_kick();
      logic [31:0] v;
      wr(4'd1, 32'd100);
      wr(4'd2, 32'h0000_1234);
      rd(4'd0, v); chk("R3 wrong key ignored", v, 32'h03EF1480);
      wr(4'd2, 32'hABCD_4755);
      rd(4'd0, v); chk("R3 key loads reload", v, 32'd100);
   endtask

   task automatic t_ctrl();
      logic [31:0] v;
      wr(4'd3, 32'h0000_0006);
      rd(4'd3, v); chk("R4 same-state write discarded", v, 32'h0);
      wr(4'd3, 32'h0000_0013);
      rd(4'd3, v); chk("R4 enable stores word", v, 32'h13);
      rd(4'd0, v); chk("R4 enable loads reload", v, 32'd100);
      wr(4'd3, 32'h0000_001F);
      rd(4'd3, v); chk("R4 enabled same-state discarded", v, 32'h13);
      tick1m(); tick1m(); tick1m();
      rd(4'd0, v); chk("R5 three slow ticks", v, 32'd97);
      wr(4'd3, 32'h0000_0000);
      rd(4'd3, v); chk("R4 disable stores word", v, 32'h0);
      tick1m();
      rd(4'd0, v); chk("R4 disabled count frozen", v, 32'd97);
   endtask

   task automatic t_fast();
      logic [31:0] v;
      int first = 0;
      int highs = 0;
      wr(4'd1, 32'd5);
      wr(4'd3, 32'h0000_0001);
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         if (timeout) begin
            highs++;
            if (first == 0) first = k;
         end
      end
      chk("R5 fast tick expiry cycle", first, 5);
      chk("R6 timeout one cycle", highs, 1);
      rd(4'd0, v); chk("R6 count stays zero", v, 32'd0);
      chk("R7 no irq when disabled", {31'd0, irq}, 32'd0);
      chk("R8 no reset when disabled", {31'd0, rst_req}, 32'd1);
      wr(4'd3, 32'h0);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(4'd6, 32'h0000_0003);
      rd(4'd6, v); chk("R10 width field written", v, 32'h3);
      wr(4'd1, 32'd2);
      wr(4'd3, 32'h0000_0017);
      tick1m();
      chk("R6 no early timeout", {31'd0, timeout}, 32'd0);
      tick1m();
      chk("R6 timeout after slow expiry", {31'd0, timeout}, 32'd1);
      @(negedge clk);
      chk("R7 irq raised", {31'd0, irq}, 32'd1);
      chk("R8 reset active low", {31'd0, rst_req}, 32'd0);
      tick1m(); tick1m();
      chk("R8 reset held two ticks", {31'd0, rst_req}, 32'd0);
      tick1m();
      chk("R8 reset released after three", {31'd0, rst_req}, 32'd1);
      chk("R7 irq held", {31'd0, irq}, 32'd1);
      wr(4'd2, 32'h0000_4755);
      chk("R7 irq cleared by key", {31'd0, irq}, 32'd0);
      rd(4'd0, v); chk("R3 restart after expiry", v, 32'd2);
      tick1m();
      rd(4'd0, v); chk("R3 restarted timer runs", v, 32'd1);
      wr(4'd3, 32'h0);
   endtask

   task automatic t_shape();
      logic [31:0] v;
      wr(4'd6, 32'hA500_0000);
      rd(4'd6, v); chk("R9 set polarity", v, 32'h8000_0000);
      chk("R8 idle low when active high", {31'd0, rst_req}, 32'd0);
      wr(4'd6, 32'hA800_0004);
      rd(4'd6, v); chk("R9 set push-pull", v, 32'hC000_0004);
      wr(4'd6, 32'h3FFF_FFFF);
      rd(4'd6, v); chk("R10 only field copied", v, 32'hC00F_FFFF);
      wr(4'd6, 32'h5A00_0000);
      rd(4'd6, v); chk("R9 clear polarity", v, 32'h4000_0000);
      wr(4'd6, 32'h8A00_0000);
      rd(4'd6, v); chk("R9 clear push-pull", v, 32'h0);
      chk("R8 idle high again", {31'd0, rst_req}, 32'd1);
      wr(4'd6, 32'hA500_0002);
      wr(4'd1, 32'd1);
      wr(4'd3, 32'h0000_0013);
      tick1m();
      @(negedge clk);
      chk("R8 active-high pulse", {31'd0, rst_req}, 32'd1);
      tick1m();
      chk("R8 high pulse held", {31'd0, rst_req}, 32'd1);
      tick1m();
      chk("R8 high pulse ended", {31'd0, rst_req}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      fork
         begin
            t_reset();
            t_map();
            t_kick();
            t_ctrl();
            t_fast();
            t_alarm();
            t_shape();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule